// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Output Scaling

This block forms a running sum of coefficient-times-sample products on two's complement fixed-point operands. It accepts one product per clock. Each operand is `DW` bits wide. The binary point can sit anywhere, from pure integers to pure fractions, and the datapath is the same for every position. The product is held in a register before the adder. The accumulator is twice the operand width plus `GUARD` extra high-order bits, so long sums do not wrap. Each product can be added to the sum or subtracted from it. A clear strobe that comes with a valid product starts a new sum from that product, with no idle cycle in between.

An output stage reduces the full-precision sum back to `DW` bits. It applies an arithmetic right shift, either rounding to nearest or truncating. If the scaled value does not fit, the result saturates and an overflow flag is raised. The shift amount and the rounding mode are applied to the accumulator value present in the same cycle. They can therefore be changed at any time to rescale a sum that is already complete.

Top module: `fxp_mac`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `acc_o`, `res_o` and `ovf_o` are all zero.
- R2: A product presented with `vld_i` high at a clock edge appears in `acc_o` two rising edges later, and products presented on consecutive cycles are all accumulated.
- R3: With `sub_i` low and `clr_i` low, a valid product is added to the accumulator.
- R4: With `sub_i` high, a valid product is subtracted from the accumulator.
- R5: With `clr_i` high, a valid product replaces the accumulator contents. The product is negated first if `sub_i` is high.
- R6: When `vld_i` is low, `clr_i`, `sub_i` and the operands have no effect, and `acc_o` holds its value.
- R7: The accumulator is `2*DW+GUARD` bits wide. Sums larger than `2^(2*DW-1)` are kept exactly, without wrapping.
- R8: With `rnd_i` low (truncate), `res_o` equals `floor(acc / 2^sh_i)`.
- R9: With `rnd_i` high (round), `res_o` equals `floor((acc + 2^(sh_i-1)) / 2^sh_i)` for `sh_i>0`, and equals `acc` when `sh_i=0`.
- R10: When the scaled value is above `2^(DW-1)-1` or below `-2^(DW-1)`, `res_o` is clamped to that bound and `ovf_o` is 1. Otherwise `ovf_o` is 0.
- R11: `res_o` and `ovf_o` are registered. They reflect `acc_o`, `sh_i` and `rnd_i` as sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operands valid this cycle |
| clr_i | input | 1 | Start a new sum with this product |
| sub_i | input | 1 | Subtract the product instead of adding |
| coef_i | input | DW | Signed coefficient |
| samp_i | input | DW | Signed sample |
| sh_i | input | SH_W | Arithmetic right-shift amount for the output |
| rnd_i | input | 1 | 1 = round to nearest, 0 = truncate |
| acc_o | output | 2*DW+GUARD | Full-precision accumulator |
| res_o | output | DW | Scaled, rounded or truncated, saturated result |
| ovf_o | output | 1 | Result was saturated |

## Verification
Two functions can land in the same cycle: a clear and a subtract on one valid product, and a new product issued back to back with an accumulate still in flight. A table of products is streamed with no gaps. It mixes clears and subtracts within the stream, and each sum is compared two cycles after issue. On the output side, rounding can push a value across the saturation bound in the same cycle. Shift amounts are chosen to sit exactly at and beside the limits, and both `res_o` and `ovf_o` are judged.

// File: rtl/fxp_mac_pkg.sv
`timescale 1ns/1ps
package fxp_mac_pkg;
  typedef enum logic {
    OUT_TRUNC = 1'b0,
    OUT_ROUND = 1'b1
  } outmode_e;
endpackage

// File: rtl/fxp_mac_mult.sv
`timescale 1ns/1ps
module fxp_mac_mult #(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_i,
  input  logic                   clr_i,
  input  logic                   sub_i,
  input  logic signed [DW-1:0]   coef_i,
  input  logic signed [DW-1:0]   samp_i,
  output logic signed [2*DW-1:0] prod_q,
  output logic                   vld_q,
  output logic                   clr_q,
  output logic                   sub_q
);
  logic signed [2*DW-1:0] prod_d;

  always_comb prod_d = coef_i * samp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
      clr_q  <= 1'b0;
      sub_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      clr_q <= clr_i;
      sub_q <= sub_i;
      if (vld_i) prod_q <= prod_d;
    end
  end
endmodule

// File: rtl/fxp_mac_accum.sv
`timescale 1ns/1ps
module fxp_mac_accum #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int PW    = 2*DW,
  localparam int ACC_W = PW + GUARD
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic                    clr_i,
  input  logic                    sub_i,
  input  logic signed [PW-1:0]    prod_i,
  output logic signed [ACC_W-1:0] acc_q
);
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    ext    = {{GUARD{prod_i[PW-1]}}, prod_i};
    addend = sub_i ? -ext : ext;
    acc_d  = clr_i ? addend : acc_q + addend;
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (vld_i) acc_q <= acc_d;
  end
endmodule

// File: rtl/fxp_mac_scale.sv
`timescale 1ns/1ps
module fxp_mac_scale
  import fxp_mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int SH_W  = 6,
  localparam int XW   = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]         sh_i,
  input  outmode_e                mode_i,
  output logic signed [DW-1:0]    res_q,
  output logic                    ovf_q
);
  localparam logic signed [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  logic signed [XW-1:0] wide;
  logic signed [XW-1:0] bias;
  logic signed [XW-1:0] shifted;
  logic [XW-DW:0]       top_bits;
  logic                 fits;
  logic signed [DW-1:0] res_d;

  always_comb begin
    wide = {acc_i[ACC_W-1], acc_i};
    if (mode_i == OUT_ROUND && sh_i != '0)
      bias = {{(XW-1){1'b0}}, 1'b1} << (sh_i - 1'b1);
    else
      bias = '0;
    shifted  = (wide + bias) >>> sh_i;
    top_bits = shifted[XW-1:DW-1];
    fits     = (&top_bits) | ~(|top_bits);
    if (fits)                  res_d = shifted[DW-1:0];
    else if (shifted[XW-1])    res_d = NEG_LIM;
    else                       res_d = POS_LIM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ~fits;
    end
  end
endmodule

// File: rtl/fxp_mac.sv
`timescale 1ns/1ps
module fxp_mac
  import fxp_mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int SH_W  = $clog2(ACC_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic                    clr_i,
  input  logic                    sub_i,
  input  logic signed [DW-1:0]    coef_i,
  input  logic signed [DW-1:0]    samp_i,
  input  logic [SH_W-1:0]         sh_i,
  input  logic                    rnd_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [DW-1:0]    res_o,
  output logic                    ovf_o
);
  logic signed [2*DW-1:0] prod_q;
  logic                   p_vld;
  logic                   p_clr;
  logic                   p_sub;
  outmode_e               mode;

  always_comb mode = rnd_i ? OUT_ROUND : OUT_TRUNC;

  fxp_mac_mult #(.DW(DW)) u_mult (
    .clk(clk), .rst(rst), .vld_i(vld_i), .clr_i(clr_i), .sub_i(sub_i),
    .coef_i(coef_i), .samp_i(samp_i),
    .prod_q(prod_q), .vld_q(p_vld), .clr_q(p_clr), .sub_q(p_sub)
  );

  fxp_mac_accum #(.DW(DW), .GUARD(GUARD)) u_accum (
    .clk(clk), .rst(rst), .vld_i(p_vld), .clr_i(p_clr), .sub_i(p_sub),
    .prod_i(prod_q), .acc_q(acc_o)
  );

  fxp_mac_scale #(.DW(DW), .ACC_W(ACC_W), .SH_W(SH_W)) u_scale (
    .clk(clk), .rst(rst), .acc_i(acc_o), .sh_i(sh_i), .mode_i(mode),
    .res_q(res_o), .ovf_q(ovf_o)
  );
endmodule

// File: rtl/fxp_mac_chk.sv
`timescale 1ns/1ps
module fxp_mac_chk #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACC_W = 2*DW + GUARD,
  localparam int SH_W  = $clog2(ACC_W)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    vld_i,
  input logic                    clr_i,
  input logic                    sub_i,
  input logic signed [DW-1:0]    coef_i,
  input logic signed [DW-1:0]    samp_i,
  input logic [SH_W-1:0]         sh_i,
  input logic                    rnd_i,
  input logic signed [ACC_W-1:0] acc_o,
  input logic signed [DW-1:0]    res_o,
  input logic                    ovf_o
);
  localparam logic signed [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_o == '0 && res_o == '0 && !ovf_o));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(vld_i) |=> $stable(acc_o));

  // R10
  sat_value_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (res_o == POS_LIM || res_o == NEG_LIM));

  // R8
  trunc_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!rnd_i && sh_i == '0) |=> (ovf_o || res_o == $past(acc_o[DW-1:0])));
endmodule

bind fxp_mac fxp_mac_chk #(.DW(DW), .GUARD(GUARD)) u_chk (.*);

// File: tb/fxp_mac_test.sv
`timescale 1ns/1ps
module fxp_mac_test;
  localparam int DW = 16;
  localparam int GUARD = 8;
  localparam int ACC_W = 2*DW + GUARD;
  localparam int SH_W = $clog2(ACC_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0, clr = 1'b0, sub = 1'b0, rnd = 1'b0;
  logic signed [DW-1:0] coef = '0, samp = '0;
  logic [SH_W-1:0] sh = '0;
  logic signed [ACC_W-1:0] acc;
  logic signed [DW-1:0] res;
  logic ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fxp_mac #(.DW(DW), .GUARD(GUARD)) uut (
    .clk(clk), .rst(rst), .vld_i(vld), .clr_i(clr), .sub_i(sub),
    .coef_i(coef), .samp_i(samp), .sh_i(sh), .rnd_i(rnd),
    .acc_o(acc), .res_o(res), .ovf_o(ovf)
  );

  typedef struct packed {
    logic              c;
    logic              s;
    logic [DW-1:0]     a;
    logic [DW-1:0]     b;
    logic [ACC_W-1:0]  e;
  } vec_t;

  // Back-to-back stream: R2 latency, R3 add, R4 subtract, R5 clear, R7 guard bits
  localparam vec_t VEC [9] = '{
    '{1'b1, 1'b0, 16'sd3,     16'sd4,     40'sd12},
    '{1'b0, 1'b0, -16'sd5,    16'sd6,     -40'sd18},
    '{1'b0, 1'b1, 16'sd7,     -16'sd2,    -40'sd4},
    '{1'b0, 1'b0, 16'sd100,   16'sd100,   40'sd9996},
    '{1'b1, 1'b1, 16'sd2,     16'sd3,     -40'sd6},
    '{1'b0, 1'b0, 16'sh7FFF,  16'sh7FFF,  40'sd1073676283},
    '{1'b0, 1'b0, 16'sh8000,  16'sh8000,  40'sd2147418107},
    '{1'b0, 1'b0, 16'sh8000,  16'sh8000,  40'sd3221159931},
    '{1'b1, 1'b0, 16'sh8000,  16'sh7FFF,  -40'sd1073709056}
  };

  task automatic chk_acc(string req, logic signed [ACC_W-1:0] exp);
    checks++;
    if (acc !== exp) begin
      errors++;
      $display("FAIL %s acc actual=%0d expected=%0d", req, acc, exp);
    end
  endtask

  task automatic chk_out(string req, logic signed [DW-1:0] er, logic eo);
    checks++;
    if (res !== er || ovf !== eo) begin
      errors++;
      $display("FAIL %s res/ovf actual=%0d/%0b expected=%0d/%0b", req, res, ovf, er, eo);
    end
  endtask

  // Start a new sum with a single product, then idle until res_o reflects it.
  task automatic load(logic signed [DW-1:0] a, logic signed [DW-1:0] b);
    @(negedge clk);
    vld = 1'b1; clr = 1'b1; sub = 1'b0; coef = a; samp = b;
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_out(int s, logic r);
    sh = SH_W'(s); rnd = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk_acc("R1", '0);
    chk_out("R1", '0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1", '0, 1'b0);

    // Streaming table, checked two edges after issue (R2)
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i >= 2) chk_acc("R2/R3/R4/R5/R7", signed'(VEC[i-2].e));
      if (i < 9) begin
        vld = 1'b1; clr = VEC[i].c; sub = VEC[i].s;
        coef = VEC[i].a; samp = VEC[i].b;
      end else begin
        vld = 1'b0; clr = 1'b0; sub = 1'b0;
      end
    end

    // R6: idle cycles with clear, subtract and operands toggling
    vld = 1'b0; clr = 1'b1; sub = 1'b1; coef = 16'sd99; samp = 16'sd99;
    repeat (4) @(negedge clk);
    chk_acc("R6", -40'sd1073709056);
    clr = 1'b0; sub = 1'b0;

    // R8 / R9 with positive and negative sums
    load(16'sd2, 16'sd7);                 // acc = 14
    set_out(2, 1'b0); chk_out("R8", 16'sd3, 1'b0);
    set_out(2, 1'b1); chk_out("R9", 16'sd4, 1'b0);
    set_out(0, 1'b1); chk_out("R9", 16'sd14, 1'b0);
    load(-16'sd2, 16'sd7);                // acc = -14
    set_out(2, 1'b0); chk_out("R8", -16'sd4, 1'b0);
    set_out(2, 1'b1); chk_out("R9", -16'sd3, 1'b0);
    load(16'sd100, 16'sd100);             // acc = 10000
    set_out(0, 1'b0); chk_out("R8", 16'sd10000, 1'b0);

    // R11: change of mode seen exactly one edge later
    load(16'sd2, 16'sd7);
    set_out(2, 1'b1); chk_out("R11", 16'sd4, 1'b0);
    @(negedge clk); rnd = 1'b0;
    checks++;
    if (res !== 16'sd4) begin
      errors++; $display("FAIL R11 res actual=%0d expected=4 before edge", res);
    end
    @(negedge clk); chk_out("R11", 16'sd3, 1'b0);

    // R10 saturation at both ends
    load(16'sh8000, 16'sh8000);           // acc = 2^30
    set_out(15, 1'b0); chk_out("R10", 16'sh7FFF, 1'b1);
    set_out(16, 1'b0); chk_out("R10", 16'sd16384, 1'b0);
    load(16'sh8000, 16'sh7FFF);           // acc = -1073709056
    set_out(15, 1'b0); chk_out("R10", -16'sd32767, 1'b0);
    set_out(14, 1'b0); chk_out("R10", 16'sh8000, 1'b1);
    load(16'sd181, 16'sd181);             // acc = 32761
    set_out(0, 1'b0); chk_out("R10", 16'sd32761, 1'b0);
    load(16'sh7FFF, 16'sd2);              // acc = 65534
    set_out(1, 1'b0); chk_out("R10", 16'sh7FFF, 1'b0);
    set_out(0, 1'b0); chk_out("R10", 16'sh7FFF, 1'b1);

    // R1: reset in mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    chk_acc("R1", '0);
    chk_out("R1", '0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule